// File: doc/BRIEF.md
# Line-Code Symbol Aligner

This block sits directly behind the serial receive pin of a block-coded link. Each clock on which the bit enable is high, it takes one line bit and turns it back into a data bit with NRZI decoding: a change of line level gives a 1 and a steady level gives a 0. It then shifts the data bit into a 5-bit window. A 5-bit symbol is only meaningful once the receiver knows where each symbol starts. The block gets that boundary from the Escape code, which a transmitter sends at the start of each cell command.

After reset, or after a pulse on the reconnect input, the block is unaligned and emits nothing. While it is unaligned, it compares the window with the Escape code after every bit. The first match fixes the symbol boundary. The Escape itself is passed out as the first symbol. From then on the block emits one symbol for every five enabled bits, together with a one-clock valid strobe. A bad flag marks any symbol whose code is absent from a 32-entry mask of legal codes. Mapping the symbols to data nibbles is left to the stage that follows.

Top module: `nrzi_sym_sync`

## Requirements
- R1: After reset, `aligned`, `symValid` and `badSym` are 0 and the NRZI reference level is 0.
- R2: On each enabled bit, the decoded data bit is `lineBit` XOR the line bit sampled on the previous enabled bit. After reset or reconnect, that previous bit is taken as 0.
- R3: While `aligned` is 0, `symValid` stays 0 except on the Escape match described in R4.
- R4: While unaligned, the last five decoded bits are compared with `ESC_CODE` after every enabled bit. The default is 5'b11000, with the earliest bit in bit 4. On a match, at any bit offset, `aligned` becomes 1 on the next clock and the Escape is output as a symbol with `symValid`.
- R5: Once aligned, every fifth enabled bit completes a symbol. That symbol appears on `symbol` with the first received bit in bit 4, and `symValid` is high for exactly one clock.
- R6: Once aligned, an Escape pattern that spans two symbols does not move the symbol boundary.
- R7: `badSym` is 1 only together with `symValid`, and only when bit `symbol` of `VALID_MASK` is 0. The default mask, 32'h7DFC_CE00, allows the sixteen data codes plus 11000.
- R8: A high `reconnect` on a clock edge restores the state after reset (R1) on the next clock, even when `bitEn` is also high.
- R9: While `bitEn` is 0, `lineBit` has no effect, and neither alignment nor bit position changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One line bit is present this clock |
| lineBit | input | 1 | NRZI-coded line level |
| reconnect | input | 1 | Synchronous return to the unaligned state |
| symbol | output | 5 | Last completed symbol, earliest bit in bit 4 |
| symValid | output | 1 | One-clock strobe for a new symbol |
| badSym | output | 1 | Symbol code is not in the legal set |
| aligned | output | 1 | Symbol boundary is locked |

## Verification
The bench finds alignment at every one of the five bit offsets. After each lock it streams all 32 codes. A design that fixes its boundary one bit late, or that drops the Escape symbol, would show shifted symbols or a missing strobe. A design that keeps hunting after it has locked would realign on a straddling Escape and corrupt later symbols. The bench also toggles the line while the bit enable is low, and asserts reconnect together with a live bit. A block whose NRZI reference follows the raw pin, or where reconnect loses to the bit enable, would then decode wrong bits or stay aligned.

// File: rtl/symsync_pkg.sv
package symsync_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // return to power-up state
    logic shift;  // accept one decoded bit
    logic emit;   // latch completed symbol
  } syncCtl_t;
endpackage

// File: rtl/symsync_datapath.sv
module symsync_datapath
  import symsync_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter logic [SYM_W-1:0] ESC_CODE = 5'b11000,
  parameter logic [(2**SYM_W)-1:0] VALID_MASK = 32'h7DFC_CE00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineBit,
  input  syncCtl_t         ctl,
  output logic             escHit,
  output logic [SYM_W-1:0] symbol,
  output logic             symValid,
  output logic             badSym
);
  logic             prevBit;
  logic [SYM_W-1:0] win;
  logic [SYM_W-1:0] nextWin;
  logic             decBit;

  assign decBit  = lineBit ^ prevBit;
  assign nextWin = {win[SYM_W-2:0], decBit};
  assign escHit  = (nextWin == ESC_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit  <= 1'b0;
      win      <= '0;
      symbol   <= '0;
      symValid <= 1'b0;
      badSym   <= 1'b0;
    end else if (ctl.clear) begin
      prevBit  <= 1'b0;
      win      <= '0;
      symbol   <= '0;
      symValid <= 1'b0;
      badSym   <= 1'b0;
    end else begin
      symValid <= ctl.emit;
      badSym   <= ctl.emit && !VALID_MASK[nextWin];
      if (ctl.shift) begin
        prevBit <= lineBit;
        win     <= nextWin;
      end
      if (ctl.emit) symbol <= nextWin;
    end
  end

  p_bad_only_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    badSym |-> symValid);
  p_bad_matches_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> (badSym == !VALID_MASK[symbol]));
endmodule

// File: rtl/symsync_ctrl.sv
module symsync_ctrl
  import symsync_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitEn,
  input  logic     reconnect,
  input  logic     escHit,
  output syncCtl_t ctl,
  output logic     aligned
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             acceptBit;

  assign acceptBit = bitEn && !reconnect;

  always_comb begin
    ctl.clear = reconnect;
    ctl.shift = acceptBit;
    ctl.emit  = acceptBit && (aligned ? (bitCnt == LAST) : escHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
      bitCnt  <= '0;
    end else if (reconnect) begin
      aligned <= 1'b0;
      bitCnt  <= '0;
    end else if (bitEn) begin
      if (!aligned) begin
        if (escHit) begin
          aligned <= 1'b1;
          bitCnt  <= '0;
        end
      end else if (bitCnt == LAST) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !reconnect) |=> ($stable(bitCnt) && $stable(aligned)));
  p_unaligned_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |-> (bitCnt == '0));
endmodule

// File: rtl/nrzi_sym_sync.sv
module nrzi_sym_sync
  import symsync_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter logic [SYM_W-1:0] ESC_CODE = 5'b11000,
  parameter logic [(2**SYM_W)-1:0] VALID_MASK = 32'h7DFC_CE00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             lineBit,
  input  logic             reconnect,
  output logic [SYM_W-1:0] symbol,
  output logic             symValid,
  output logic             badSym,
  output logic             aligned
);
  syncCtl_t ctl;
  logic     escHit;

  symsync_ctrl #(.SYM_W(SYM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .reconnect(reconnect),
    .escHit(escHit), .ctl(ctl), .aligned(aligned)
  );

  symsync_datapath #(.SYM_W(SYM_W), .ESC_CODE(ESC_CODE),
                     .VALID_MASK(VALID_MASK)) uData (
    .clk(clk), .rstN(rstN), .lineBit(lineBit), .ctl(ctl), .escHit(escHit),
    .symbol(symbol), .symValid(symValid), .badSym(badSym)
  );

  p_valid_needs_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    symValid |-> aligned);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> !symValid);
  p_reconnect_r8: assert property (@(posedge clk) disable iff (!rstN)
    reconnect |=> (!aligned && !symValid && !badSym));
  p_lock_emits_esc_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aligned) |-> (symValid && symbol == ESC_CODE));
endmodule

// File: tb/tb_nrzi_sym_sync.sv
module tb_nrzi_sym_sync;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0]  ESC  = 5'b11000;
  localparam logic [31:0] MASK = 32'h7DFC_CE00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic lineBit = 1'b0;
  logic reconnect = 1'b0;
  logic [4:0] symbol;
  logic symValid, badSym, aligned;

  int nChecks = 0;
  int nFails = 0;
  logic lineState = 1'b0;  // bench NRZI encoder state (R2)

  always #(CLK_PERIOD/2) clk = ~clk;

  nrzi_sym_sync dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .lineBit(lineBit),
    .reconnect(reconnect), .symbol(symbol), .symValid(symValid),
    .badSym(badSym), .aligned(aligned)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // send one decoded bit; check strobe/symbol after the edge, then pulse end
  task automatic sendBit(input logic d, input bit expV, input logic [4:0] expCode,
                         input string req);
    @(negedge clk);
    lineState = lineState ^ d;
    lineBit = lineState;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    check(symValid == expV, req, "symValid", int'(symValid), int'(expV));
    if (expV) begin
      check(symbol == expCode, req, "symbol", int'(symbol), int'(expCode));
      check(badSym == !MASK[expCode], "R7", "badSym", int'(badSym), int'(!MASK[expCode]));
    end else begin
      check(badSym == 1'b0, "R7", "badSym idle", int'(badSym), 0);
    end
    @(negedge clk);
    check(symValid == 1'b0, "R5", "pulse width", int'(symValid), 0);
  endtask

  task automatic sendSym(input logic [4:0] c, input string req);
    for (int i = 4; i >= 0; i--)
      sendBit(c[i], (i == 0), c, req);
  endtask

  task automatic doReconnect(input logic withBit);
    @(negedge clk);
    reconnect = 1'b1;
    bitEn = withBit;
    lineBit = ~lineBit;
    @(negedge clk);
    reconnect = 1'b0;
    bitEn = 1'b0;
    lineState = 1'b0;
    check(aligned == 1'b0, "R8", "aligned after reconnect", int'(aligned), 0);
    check(symValid == 1'b0, "R8", "symValid after reconnect", int'(symValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(aligned == 1'b0, "R1", "aligned at reset", int'(aligned), 0);
    check(symValid == 1'b0, "R1", "symValid at reset", int'(symValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(aligned == 1'b0 && badSym == 1'b0, "R1", "idle after reset", int'(aligned), 0);

    // R3: no strobes while unaligned on a quiet line
    for (int i = 0; i < 12; i++) sendBit(1'b0, 1'b0, 5'd0, "R3");

    for (int off = 0; off < 5; off++) begin
      doReconnect(off[0]);
      // prefix of zero bits sets the offset (R4 lock at any offset)
      for (int i = 0; i < off + 2; i++) sendBit(1'b0, 1'b0, 5'd0, "R3");
      // Escape: strobe only on its last bit (R4)
      for (int i = 4; i >= 0; i--) sendBit(ESC[i], (i == 0), ESC, "R4");
      check(aligned == 1'b1, "R4", "aligned after escape", int'(aligned), 1);
      // R5/R2/R7: every code, MSB first
      for (int c = 0; c < 32; c++) sendSym(5'(c), "R5");
      // R6: escape straddling 00011|00000 must not reframe
      sendSym(5'b00011, "R6");
      sendSym(5'b00000, "R6");
      sendSym(5'b10101, "R6");
      // R9: line toggles with bitEn low are ignored
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        lineBit = ~lineBit;
      end
      @(negedge clk);
      check(aligned == 1'b1 && symValid == 1'b0, "R9", "idle toggles", int'(aligned), 1);
      sendSym(5'b01110, "R9");
      sendSym(5'b11001, "R9");
    end

    // R8: reconnect wins over a live bit; then unaligned again (R3)
    doReconnect(1'b1);
    for (int i = 0; i < 7; i++) sendBit(1'b1, 1'b0, 5'd0, "R3");
    check(aligned == 1'b0, "R3", "still unaligned", int'(aligned), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule